// File: doc/BRIEF.md
# Chip-Select Region Decoder

This block sits between a system request port and an external memory controller. Every request address is compared at once against a set of programmable address windows, one per chip-select. A window is described by a base, a mask and an enable flag. The address falls inside a window when the bits picked out by the mask equal the same bits of the base. The block forwards the access only when exactly one enabled window claims the address. In that case it raises the matching chip-select line and a forward strobe.

Any other outcome blocks the access and flags it as faulty. This covers an address that no enabled window claims, an address whose only matching window is switched off, and an address claimed by two or more enabled windows. A faulty request produces a one-cycle error pulse. It also latches the failing address and sets a sticky fault flag, which software clears by writing a one. The decode result is registered, so it appears on the outputs one cycle after the request strobe.

The window settings are loaded through a small write port. That port selects a region index and a field: base, mask, enable or fault-clear. After reset only window 0 is live. It has base 0 and a mask covering the top address nibble, so it claims the lowest 256 MiB. All other windows start disabled.

Top module: `csreg_decoder`

## Requirements
- R1: After reset only region 0 is enabled, with base 0x0000_0000 and mask 0xF000_0000. All outputs are low, and the latched fault address is zero.
- R2: A request whose address is claimed by exactly one enabled region raises only that region's bit in `cs_sel` and raises `ext_strobe`, one cycle after `req_valid`.
- R3: A request claimed by no enabled region gives `err_pulse` high for exactly one cycle, one cycle after `req_valid`, with `cs_sel` zero and `ext_strobe` low.
- R4: A request matching only a region whose enable bit is clear is treated as a fault, as in R3.
- R5: A request claimed by two or more enabled regions is a fault: `err_pulse` rises and no chip-select bit is raised.
- R6: Region i claims address A when (A & mask_i) == (base_i & mask_i). A mask bit of 1 means the address bit is compared.
- R7: On every fault, `err_addr` takes the faulting address. It keeps that value through later good accesses until the next fault.
- R8: `err_sticky` is set by every fault. It is cleared by a write with field code 3 and `cfg_wdata[0]`=1; a write of 0 with that code has no effect. A fault in the same cycle as a clear leaves it set.
- R9: A configuration write is applied at the clock edge that samples it. A request sampled at that same edge is decoded with the settings from before the write. Field codes are 0 base, 1 mask, 2 enable (`cfg_wdata[0]`).
- R10: At most one bit of `cs_sel` is high in any cycle, and `ext_strobe` is high exactly when `cs_sel` is non-zero.
- R11: In a cycle after one with `req_valid` low, `cs_sel`, `ext_strobe` and `err_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | SELW | Region index for the write |
| cfg_field | input | 2 | 0 base, 1 mask, 2 enable, 3 fault-clear |
| cfg_wdata | input | ADDR_W | Write data |
| cs_sel | output | NUM_REGIONS | One-hot chip-select vector |
| ext_strobe | output | 1 | Access forwarded to the external side |
| err_pulse | output | 1 | One-cycle fault indication |
| err_addr | output | ADDR_W | Address of the latest fault |
| err_sticky | output | 1 | Fault flag held until cleared |

## Verification
Two pairs of events can land on the same clock edge, and both are forced on purpose. In the first pair, a fault-clear write arrives in the same cycle as a faulting request; the bench expects both `err_pulse` and `err_sticky` high one cycle later. In the second pair, an enable write for a window arrives in the same cycle as a request aimed at that window. The bench expects a fault, because the old settings are used, and then expects a clean hit on the next request.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  typedef enum logic [1:0] {
    FLD_BASE   = 2'd0,
    FLD_MASK   = 2'd1,
    FLD_ENABLE = 2'd2,
    FLD_STATUS = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/csdec_region_bank.sv
module csdec_region_bank #(
  parameter int NUM_REGIONS = 7,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_BASE0 = '0,
  parameter logic [ADDR_W-1:0] RESET_MASK0 = '0,
  localparam int SELW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [SELW-1:0]                    sel,
  input  csdec_pkg::cfg_field_e              field,
  input  logic [ADDR_W-1:0]                  wdata,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_o,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0] mask_o,
  output logic [NUM_REGIONS-1:0]             en_o
);
  import csdec_pkg::*;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    localparam logic [ADDR_W-1:0] BASE_INIT = (i == 0) ? RESET_BASE0 : '0;
    localparam logic [ADDR_W-1:0] MASK_INIT = (i == 0) ? RESET_MASK0 : '0;
    localparam logic              EN_INIT   = (i == 0);

    logic hit_sel;
    assign hit_sel = we && (sel == SELW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[i] <= BASE_INIT;
        mask_o[i] <= MASK_INIT;
        en_o[i]   <= EN_INIT;
      end else if (hit_sel) begin
        case (field)
          FLD_BASE:   base_o[i] <= wdata;
          FLD_MASK:   mask_o[i] <= wdata;
          FLD_ENABLE: en_o[i]   <= wdata[0];
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/csdec_match.sv
module csdec_match #(
  parameter int NUM_REGIONS = 7,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_i,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] mask_i,
  input  logic [NUM_REGIONS-1:0]             en_i,
  output logic [NUM_REGIONS-1:0]             raw_vec,
  output logic [NUM_REGIONS-1:0]             hit_vec
);
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [ADDR_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
    assign raw_vec[i] = in_window(addr, base_i[i], mask_i[i]);
    assign hit_vec[i] = raw_vec[i] && en_i[i];
  end
endmodule

// File: rtl/csdec_resolve.sv
module csdec_resolve #(
  parameter int NUM_REGIONS = 7,
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [NUM_REGIONS-1:0] hit_vec,
  input  logic                   clr_sticky,
  output logic                   single_hit,
  output logic                   fault_evt,
  output logic [NUM_REGIONS-1:0] cs_q,
  output logic                   strobe_q,
  output logic                   err_q,
  output logic [ADDR_W-1:0]      err_addr_q,
  output logic                   sticky_q
);
  function automatic logic is_single(input logic [NUM_REGIONS-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

  assign single_hit = is_single(hit_vec);
  assign fault_evt  = req_valid && !single_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= '0;
      strobe_q   <= 1'b0;
      err_q      <= 1'b0;
      err_addr_q <= '0;
      sticky_q   <= 1'b0;
    end else begin
      cs_q     <= (req_valid && single_hit) ? hit_vec : '0;
      strobe_q <= req_valid && single_hit;
      err_q    <= fault_evt;
      if (fault_evt) begin
        err_addr_q <= req_addr;
        sticky_q   <= 1'b1;
      end else if (clr_sticky) begin
        sticky_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csreg_decoder.sv
module csreg_decoder #(
  parameter int NUM_REGIONS = 7,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_BASE0 = '0,
  parameter logic [ADDR_W-1:0] RESET_MASK0 = {4'hF, {(ADDR_W-4){1'b0}}},
  localparam int SELW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   cfg_we,
  input  logic [SELW-1:0]        cfg_sel,
  input  logic [1:0]             cfg_field,
  input  logic [ADDR_W-1:0]      cfg_wdata,
  output logic [NUM_REGIONS-1:0] cs_sel,
  output logic                   ext_strobe,
  output logic                   err_pulse,
  output logic [ADDR_W-1:0]      err_addr,
  output logic                   err_sticky
);
  import csdec_pkg::*;

  cfg_field_e                         field_e;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_w;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] mask_w;
  logic [NUM_REGIONS-1:0]             en_w;
  logic [NUM_REGIONS-1:0]             raw_vec;
  logic [NUM_REGIONS-1:0]             hit_vec;
  logic                               clr_sticky;
  logic                               single_hit;
  logic                               fault_evt;

  assign field_e    = cfg_field_e'(cfg_field);
  assign clr_sticky = cfg_we && (field_e == FLD_STATUS) && cfg_wdata[0];

  csdec_region_bank #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W),
    .RESET_BASE0(RESET_BASE0), .RESET_MASK0(RESET_MASK0)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .field(field_e), .wdata(cfg_wdata),
    .base_o(base_w), .mask_o(mask_w), .en_o(en_w)
  );

  csdec_match #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_match (
    .addr(req_addr), .base_i(base_w), .mask_i(mask_w), .en_i(en_w),
    .raw_vec(raw_vec), .hit_vec(hit_vec)
  );

  csdec_resolve #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_resolve (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .hit_vec(hit_vec), .clr_sticky(clr_sticky),
    .single_hit(single_hit), .fault_evt(fault_evt),
    .cs_q(cs_sel), .strobe_q(ext_strobe), .err_q(err_pulse),
    .err_addr_q(err_addr), .sticky_q(err_sticky)
  );
endmodule

// File: rtl/csdec_checker.sv
module csdec_checker #(
  parameter int N = 7,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [N-1:0]  hit_vec,
  input logic          clr_sticky,
  input logic [N-1:0]  cs_sel,
  input logic          ext_strobe,
  input logic          err_pulse,
  input logic [AW-1:0] err_addr,
  input logic          err_sticky
);
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));

  a_r10_strobe_match: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strobe == (cs_sel != '0));

  a_r2_single_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $countones(hit_vec) == 1) |=> (ext_strobe && cs_sel == $past(hit_vec)));

  a_r5_overlap_block: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $countones(hit_vec) > 1) |=> (err_pulse && cs_sel == '0));

  a_r3_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (!ext_strobe && cs_sel == '0));

  a_r7_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $countones(hit_vec) != 1) |=> (err_addr == $past(req_addr)));

  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  a_r8_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sticky && !(req_valid && $countones(hit_vec) != 1)) |=> !err_sticky);

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!ext_strobe && !err_pulse && cs_sel == '0));
endmodule

bind csreg_decoder csdec_checker #(.N(NUM_REGIONS), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .hit_vec(hit_vec), .clr_sticky(clr_sticky), .cs_sel(cs_sel),
  .ext_strobe(ext_strobe), .err_pulse(err_pulse), .err_addr(err_addr),
  .err_sticky(err_sticky)
);

// File: tb/csreg_decoder_bench.sv
module csreg_decoder_bench;
  localparam int N  = 7;
  localparam int AW = 32;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [1:0]    cfg_field = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [N-1:0]  cs_sel;
  logic          ext_strobe;
  logic          err_pulse;
  logic [AW-1:0] err_addr;
  logic          err_sticky;

  int nvec = 0;
  int nerr = 0;
  logic [AW-1:0] last_fault = '0;

  always #10 clk = ~clk;

  csreg_decoder u_csreg_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .cs_sel(cs_sel), .ext_strobe(ext_strobe), .err_pulse(err_pulse),
    .err_addr(err_addr), .err_sticky(err_sticky)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int field, input logic [AW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = SW'(sel); cfg_field = 2'(field); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // request then check the registered result one cycle later
  task automatic do_req(input string tag, input logic [AW-1:0] a, input logic [N-1:0] exp_cs);
    logic exp_err;
    exp_err = (exp_cs == '0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_err) last_fault = a;
    chk({tag, " cs_sel"}, 64'(cs_sel), 64'(exp_cs));
    chk({tag, " ext_strobe"}, 64'(ext_strobe), 64'(!exp_err));
    chk({tag, " err_pulse"}, 64'(err_pulse), 64'(exp_err));
    chk({tag, " R7 err_addr"}, 64'(err_addr), 64'(last_fault));
    chk({tag, " R10 onehot"}, 64'($countones(cs_sel) <= 1), 64'(1));
    if (exp_err) chk({tag, " R8 sticky"}, 64'(err_sticky), 64'(1));
  endtask

  task automatic t_reset;
    chk("R1 reset cs_sel", 64'(cs_sel), 64'(0));
    chk("R1 reset strobe", 64'(ext_strobe), 64'(0));
    chk("R1 reset err", 64'(err_pulse), 64'(0));
    chk("R1 reset sticky", 64'(err_sticky), 64'(0));
    chk("R1 reset err_addr", 64'(err_addr), 64'(0));
    do_req("R1 R6 region0 low", 32'h0000_1234, 7'b000_0001);
    do_req("R1 R6 region0 top edge", 32'h0FFF_FFFF, 7'b000_0001);
    do_req("R1 R3 outside region0", 32'h1000_0000, 7'b000_0000);
  endtask

  task automatic t_enable_and_overlap;
    cfg_write(2, 0, 32'h2000_0000);
    cfg_write(2, 1, 32'hF000_0000);
    do_req("R4 disabled region", 32'h2000_0010, 7'b000_0000);
    cfg_write(2, 2, 32'h1);
    do_req("R2 region2 hit", 32'h2000_0010, 7'b000_0100);
    cfg_write(3, 0, 32'h2000_8000);
    cfg_write(3, 1, 32'hFFFF_8000);
    cfg_write(3, 2, 32'h1);
    do_req("R5 overlap 2 and 3", 32'h2000_8004, 7'b000_0000);
    do_req("R6 region2 only", 32'h2000_0004, 7'b000_0100);
    cfg_write(3, 2, 32'h0);
    do_req("R4 R6 overlap gone", 32'h2000_8004, 7'b000_0100);
    cfg_write(6, 0, 32'h6000_0000);
    cfg_write(6, 1, 32'hF000_0000);
    cfg_write(6, 2, 32'h1);
    do_req("R2 top region", 32'h6ABC_0000, 7'b100_0000);
  endtask

  task automatic t_sticky;
    chk("R8 sticky before clear", 64'(err_sticky), 64'(1));
    cfg_write(0, 3, 32'h0);
    chk("R8 clear with zero ignored", 64'(err_sticky), 64'(1));
    cfg_write(5, 3, 32'h1);
    chk("R8 clear", 64'(err_sticky), 64'(0));
    // clear and fault on the same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = '0; cfg_field = 2'd3; cfg_wdata = 32'h1;
    req_valid = 1'b1; req_addr = 32'h3000_0000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    last_fault = 32'h3000_0000;
    chk("R8 fault beats clear sticky", 64'(err_sticky), 64'(1));
    chk("R8 fault beats clear pulse", 64'(err_pulse), 64'(1));
    chk("R7 same-cycle fault addr", 64'(err_addr), 64'(32'h3000_0000));
    do_req("R7 good access keeps addr", 32'h0000_0040, 7'b000_0001);
  endtask

  task automatic t_write_vs_request;
    cfg_write(4, 0, 32'h4000_0000);
    cfg_write(4, 1, 32'hF000_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd4; cfg_field = 2'd2; cfg_wdata = 32'h1;
    req_valid = 1'b1; req_addr = 32'h4000_0000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    last_fault = 32'h4000_0000;
    chk("R9 old settings used", 64'(err_pulse), 64'(1));
    chk("R9 no cs on old settings", 64'(cs_sel), 64'(0));
    do_req("R9 new settings next", 32'h4000_0000, 7'b001_0000);
  endtask

  task automatic t_idle;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 idle cs_sel", 64'(cs_sel), 64'(0));
      chk("R11 R3 idle err one cycle", 64'(err_pulse), 64'(0));
      chk("R11 R10 idle strobe", 64'(ext_strobe), 64'(0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_and_overlap();
    t_sticky();
    t_write_vs_request();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule